// File: doc/BRIEF.md
# Asynchronous Parallel ROM Read Controller

This block sits on a synchronous bus and fetches 16-bit words from an external asynchronous ROM of 131072 words (17 address lines). A host raises a one-cycle request with a word address. The controller then drives the address, pulls the active-low chip select low at once, and pulls the active-low output strobe low later. It waits a fixed number of clock cycles, captures the data bus, and presents the word with a one-cycle valid pulse. It then holds off the next access until the ROM has had time to stop driving the shared data bus.

All waits come from nanosecond limits chosen by a speed-grade parameter. Grades 0 to 5 have address and select access times of 70, 90, 120, 150, 200 and 250 ns, output-strobe access times of 40, 40, 50, 65, 75 and 75 ns, and float-to-high-Z times of 25, 25, 30, 30, 40 and 60 ns. A second parameter gives the clock period. Each limit is turned into a cycle count when the design elaborates: divide by the period, round up, then add one cycle of margin for input capture. The output strobe is held back by the difference between the access count and the strobe count. This keeps it low only as long as the access needs, and it never goes low later than the ROM allows.

Top module: `prom_rd_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `rom_ce_n` and `rom_oe_n` are 1 and `busy` and `rvalid` are 0.
- R2: A `req` sampled while `busy` is 0 is accepted at that clock edge. After that edge, `rom_addr` equals the requested address, `rom_ce_n` is 0 and `busy` is 1.
- R3: The edge that accepts a request is edge 0. `rom_oe_n` is 0 after edges LEAD through ACC-1 and 1 at all other times, where LEAD = ACC - OEC. `rom_oe_n` is never 0 while `rom_ce_n` is 1.
- R4: `rvalid` is 1 for exactly the one cycle after edge ACC. At that point `rdata` holds the ROM word stored at the accepted address.
- R5: The data bus is sampled at edge ACC. `rom_ce_n` and `rom_oe_n` both return to 1 at that same edge, and not before it.
- R6: `busy` stays 1 until edge ACC+DF and is 0 after it. `rom_ce_n` never falls within the grade's float time after the previous access released the bus.
- R7: A `req` raised while `busy` is 1 is ignored. No second access starts, `rom_addr` does not change, and no extra `rvalid` appears.
- R8: ACC, OEC and DF each equal ceil(limit_ns / CLK_PERIOD_NS) + 1, where the limit is the grade's access, output-strobe or float time. With the default 10 ns clock and grade 0, ACC = 8, OEC = 5, LEAD = 3 and DF = 4.
- R9: `rdata` keeps its value in every cycle where `rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Read request, taken when not busy |
| req_addr | input | 17 | Word address of the request |
| busy | output | 1 | Access or bus-release gap in progress |
| rdata | output | 16 | Captured word |
| rvalid | output | 1 | One-cycle pulse when `rdata` is new |
| rom_addr | output | 17 | Address lines to the ROM |
| rom_ce_n | output | 1 | Chip select to the ROM, active low |
| rom_oe_n | output | 1 | Output strobe to the ROM, active low |
| rom_dq | input | 16 | Data lines from the ROM |

## Verification
The bench drives a timed ROM model that puts unknowns on the bus until every access limit has passed, and keeps unknowns on the bus for the float time after release. A controller that samples one cycle early, or drops its strobes before sampling, therefore captures unknowns rather than the stored word. Each read is traced cycle by cycle against the ACC, LEAD and DF counts. A strobe that starts late, a short access count, or a short release gap each shows up as a mismatch in a named cycle. A monitor records the moment the bus is released and flags any new select that falls inside the float window. Back-to-back reads, reads at the lowest and highest addresses, and a request raised in the middle of an access confirm that queued or early requests neither start a second access nor disturb the word being returned.

// File: rtl/prom_rd_pkg.sv
`timescale 1ns/1ps
package prom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } rd_state_e;

  // Worst-case address / select access time by speed grade.
  function automatic int unsigned grade_acc_ns(input int unsigned g);
    case (g)
      0:       return 70;
      1:       return 90;
      2:       return 120;
      3:       return 150;
      4:       return 200;
      default: return 250;
    endcase
  endfunction

  // Worst-case output-strobe access time by speed grade.
  function automatic int unsigned grade_oe_ns(input int unsigned g);
    case (g)
      0, 1:    return 40;
      2:       return 50;
      3:       return 65;
      default: return 75;
    endcase
  endfunction

  // Worst-case time for the ROM outputs to float after release.
  function automatic int unsigned grade_df_ns(input int unsigned g);
    case (g)
      0, 1:    return 25;
      2, 3:    return 30;
      4:       return 40;
      default: return 60;
    endcase
  endfunction

  // Round up to whole cycles and add one cycle of capture margin.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns + 1;
  endfunction

endpackage

// File: rtl/prom_strobe_seq.sv
`timescale 1ns/1ps
module prom_strobe_seq
  import prom_rd_pkg::*;
#(
  parameter int unsigned AW       = 17,
  parameter int unsigned ACC_CYC  = 8,
  parameter int unsigned LEAD_CYC = 3,
  parameter int unsigned DF_CYC   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  output logic          busy,
  output logic [AW-1:0] rom_addr,
  output logic          rom_ce_n,
  output logic          rom_oe_n,
  output logic          cap
);

  localparam int unsigned MAXC    = (ACC_CYC > DF_CYC) ? ACC_CYC : DF_CYC;
  localparam int unsigned CW      = $clog2(MAXC + 1);
  localparam bit          LATE_OE = (LEAD_CYC > 0);
  localparam int unsigned LEAD_M1 = LATE_OE ? LEAD_CYC - 1 : 0;

  rd_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic          ce_q, oe_q, busy_q;
  logic          acc_done, flt_done, oe_due;

  assign acc_done = (st_q == ST_ACCESS) && (cnt_q == CW'(ACC_CYC - 1));
  assign flt_done = (st_q == ST_FLOAT)  && (cnt_q == CW'(DF_CYC - 1));
  assign oe_due   = LATE_OE && (st_q == ST_ACCESS) && (cnt_q == CW'(LEAD_M1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      ce_q   <= 1'b1;
      oe_q   <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req) begin
            st_q   <= ST_ACCESS;
            cnt_q  <= '0;
            addr_q <= req_addr;
            ce_q   <= 1'b0;
            oe_q   <= LATE_OE;
            busy_q <= 1'b1;
          end
        end
        ST_ACCESS: begin
          cnt_q <= cnt_q + 1'b1;
          if (oe_due) oe_q <= 1'b0;
          if (acc_done) begin
            st_q  <= ST_FLOAT;
            cnt_q <= '0;
            ce_q  <= 1'b1;
            oe_q  <= 1'b1;
          end
        end
        ST_FLOAT: begin
          cnt_q <= cnt_q + 1'b1;
          if (flt_done) begin
            st_q   <= ST_IDLE;
            busy_q <= 1'b0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = busy_q;
  assign rom_addr = addr_q;
  assign rom_ce_n = ce_q;
  assign rom_oe_n = oe_q;
  assign cap      = acc_done;

  // R2: an idle request starts an access on the next cycle
  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy && req) |=> (!rom_ce_n && busy));

  // R3: output strobe only inside the select window
  a_r3_oe_in_ce: assert property (@(posedge clk) disable iff (rst)
    !rom_oe_n |-> !rom_ce_n);

  // R5: both strobes released right after capture
  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    cap |=> (rom_ce_n && rom_oe_n));

  // R6: a new select never starts from a busy cycle
  a_r6_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(rom_ce_n) |-> !$past(busy));

  // R7: address frozen while the select stays low
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!rom_ce_n && !$past(rom_ce_n)) |-> $stable(rom_addr));

endmodule

// File: rtl/prom_data_cap.sv
`timescale 1ns/1ps
module prom_data_cap #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [DW-1:0] dq,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  logic [DW-1:0] data_q;
  logic          vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= cap;
      if (cap) data_q <= dq;
    end
  end

  assign rdata  = data_q;
  assign rvalid = vld_q;

  // R4: valid is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);

  // R9: word held between pulses
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> $stable(rdata));

endmodule

// File: rtl/prom_rd_ctrl.sv
`timescale 1ns/1ps
module prom_rd_ctrl
  import prom_rd_pkg::*;
#(
  parameter int unsigned AW            = 17,
  parameter int unsigned DW            = 16,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned GRADE         = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  output logic          busy,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic [AW-1:0] rom_addr,
  output logic          rom_ce_n,
  output logic          rom_oe_n,
  input  logic [DW-1:0] rom_dq
);

  // R8: nanosecond limits converted to cycles at elaboration
  localparam int unsigned ACC_CYC  = ns_to_cycles(grade_acc_ns(GRADE), CLK_PERIOD_NS);
  localparam int unsigned OE_CYC   = ns_to_cycles(grade_oe_ns(GRADE), CLK_PERIOD_NS);
  localparam int unsigned DF_CYC   = ns_to_cycles(grade_df_ns(GRADE), CLK_PERIOD_NS);
  localparam int unsigned LEAD_CYC = (ACC_CYC > OE_CYC) ? ACC_CYC - OE_CYC : 0;

  logic cap;

  prom_strobe_seq #(
    .AW       (AW),
    .ACC_CYC  (ACC_CYC),
    .LEAD_CYC (LEAD_CYC),
    .DF_CYC   (DF_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .req_addr (req_addr),
    .busy     (busy),
    .rom_addr (rom_addr),
    .rom_ce_n (rom_ce_n),
    .rom_oe_n (rom_oe_n),
    .cap      (cap)
  );

  prom_data_cap #(
    .DW (DW)
  ) u_cap (
    .clk    (clk),
    .rst    (rst),
    .cap    (cap),
    .dq     (rom_dq),
    .rdata  (rdata),
    .rvalid (rvalid)
  );

  // R4: a capture only while both strobes are low
  a_r4_cap_enabled: assert property (@(posedge clk) disable iff (rst)
    cap |-> (!rom_ce_n && !rom_oe_n));

endmodule

// File: tb/prom_rd_ctrl_bench.sv
`timescale 1ns/1ps
module prom_rd_ctrl_bench;

  localparam int CLK_NS = 10;
  localparam int GRADE  = 0;
  localparam int AW     = 17;
  localparam int DW     = 16;

  function automatic int acc_ns(input int g);
    case (g) 0: return 70; 1: return 90; 2: return 120; 3: return 150; 4: return 200; default: return 250; endcase
  endfunction
  function automatic int oe_ns(input int g);
    case (g) 0, 1: return 40; 2: return 50; 3: return 65; default: return 75; endcase
  endfunction
  function automatic int df_ns(input int g);
    case (g) 0, 1: return 25; 2, 3: return 30; 4: return 40; default: return 60; endcase
  endfunction

  localparam int TACC = acc_ns(GRADE);
  localparam int TOE  = oe_ns(GRADE);
  localparam int TDF  = df_ns(GRADE);
  localparam int ACC  = (TACC + CLK_NS - 1) / CLK_NS + 1;
  localparam int OEC  = (TOE + CLK_NS - 1) / CLK_NS + 1;
  localparam int DF   = (TDF + CLK_NS - 1) / CLK_NS + 1;
  localparam int LEAD = ACC - OEC;

  logic          clk = 1'b0;
  logic          rst;
  logic          req;
  logic [AW-1:0] req_addr;
  logic          busy, rvalid, rom_ce_n, rom_oe_n;
  logic [DW-1:0] rdata;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] dq_m;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  always #(CLK_NS / 2) clk = ~clk;

  prom_rd_ctrl #(
    .AW (AW), .DW (DW), .CLK_PERIOD_NS (CLK_NS), .GRADE (GRADE)
  ) u_prom_rd_ctrl (
    .clk (clk), .rst (rst), .req (req), .req_addr (req_addr),
    .busy (busy), .rdata (rdata), .rvalid (rvalid),
    .rom_addr (rom_addr), .rom_ce_n (rom_ce_n), .rom_oe_n (rom_oe_n),
    .rom_dq (dq_m)
  );

  function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
    return {a[7:0], a[15:8]} ^ {DW{a[16]}} ^ 16'h3C5A;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // ---------------- timed ROM model ----------------
  real t_addr = 0.0, t_ce = 0.0, t_oe = 0.0, t_off = -1000.0;
  bit  en_prev = 0;

  always @(rom_addr) t_addr = $realtime;
  always @(negedge rom_oe_n) t_oe = $realtime;
  always @(negedge rom_ce_n) begin
    t_ce = $realtime;
    // R6: no new select inside the float window
    chk($realtime >= t_off + TDF, "R6", "select inside float window (ns since release)",
        32'($rtoi($realtime - t_off)), 32'(TDF));
  end
  always @(rom_ce_n or rom_oe_n) begin
    if (en_prev && !(rom_ce_n === 1'b0 && rom_oe_n === 1'b0)) t_off = $realtime;
    en_prev = (rom_ce_n === 1'b0 && rom_oe_n === 1'b0);
  end

  initial begin
    dq_m = 'z;
    #0.25;
    forever begin
      if (rom_ce_n === 1'b0 && rom_oe_n === 1'b0) begin
        if ($realtime >= t_addr + TACC && $realtime >= t_ce + TACC && $realtime >= t_oe + TOE)
          dq_m = rom_word(rom_addr);
        else
          dq_m = 'x;
      end else if ($realtime < t_off + TDF) begin
        dq_m = 'x;
      end else begin
        dq_m = 'z;
      end
      #0.5;
    end
  end

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst = 1'b1; req = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    chk(rom_ce_n === 1'b1 && rom_oe_n === 1'b1, "R1", "strobes in reset", {30'd0, rom_ce_n, rom_oe_n}, 32'h3);
    chk(busy === 1'b0 && rvalid === 1'b0, "R1", "busy/rvalid in reset", {30'd0, busy, rvalid}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(rom_ce_n === 1'b1 && busy === 1'b0, "R1", "idle after reset", {30'd0, rom_ce_n, busy}, 32'h2);
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    int bad_oe = -1, bad_ce = -1, bad_rv = -1, bad_bz = -1;
    while (busy !== 1'b0) @(negedge clk);
    req = 1'b1; req_addr = a;
    @(negedge clk);
    req = 1'b0;
    // R2: access begins after the accepting edge
    chk(rom_ce_n === 1'b0 && busy === 1'b1 && rom_addr === a, "R2", "accept",
        {13'd0, rom_ce_n, busy, rom_addr}, {13'd0, 2'b01, a});
    for (int j = 0; j <= ACC + DF; j++) begin
      if (j > 0) @(negedge clk);
      if (rom_oe_n !== ((j >= LEAD && j < ACC) ? 1'b0 : 1'b1) && bad_oe < 0) bad_oe = j;
      if (rom_ce_n !== ((j < ACC) ? 1'b0 : 1'b1) && bad_ce < 0) bad_ce = j;
      if (rvalid !== ((j == ACC) ? 1'b1 : 1'b0) && bad_rv < 0) bad_rv = j;
      if (busy !== ((j < ACC + DF) ? 1'b1 : 1'b0) && bad_bz < 0) bad_bz = j;
      if (j == ACC)
        chk(rdata === rom_word(a), "R4", "captured word", {16'd0, rdata}, {16'd0, rom_word(a)});
    end
    chk(bad_oe < 0, "R3", "oe window (first bad cycle)", 32'(bad_oe), 32'hFFFFFFFF);
    chk(bad_ce < 0, "R5", "ce window (first bad cycle)", 32'(bad_ce), 32'hFFFFFFFF);
    chk(bad_rv < 0, "R8", "rvalid at ACC cycles (first bad cycle)", 32'(bad_rv), 32'hFFFFFFFF);
    chk(bad_bz < 0, "R6", "busy gap (first bad cycle)", 32'(bad_bz), 32'hFFFFFFFF);
  endtask

  task automatic t_counts();
    // R8: grade 0 at 10 ns must give 8 / 5 / 3 / 4
    chk(ACC == 8 && OEC == 5 && LEAD == 3 && DF == 4, "R8", "bench cycle counts",
        32'(ACC * 1000 + OEC * 100 + LEAD * 10 + DF), 32'd8534);
  endtask

  task automatic t_edges();
    do_read(17'h00000);
    do_read(17'h1FFFF);
    do_read(17'h0AAAA);
    do_read(17'h15555);
  endtask

  task automatic t_hold();
    logic [DW-1:0] keep;
    do_read(17'h12345);
    keep = rdata;
    repeat (6) @(negedge clk);
    // R9: rdata held while no new pulse
    chk(rdata === keep && rvalid === 1'b0, "R9", "rdata hold", {16'd0, rdata}, {16'd0, keep});
  endtask

  task automatic t_busy_ignore();
    int extra = 0;
    fork
      do_read(17'h0F0F0);
      begin
        repeat (3) @(negedge clk);
        req = 1'b1; req_addr = 17'h10101;
        repeat (2) @(negedge clk);
        req = 1'b0;
      end
    join
    for (int k = 0; k < ACC + 2; k++) begin
      if (rom_ce_n !== 1'b1 || rvalid !== 1'b0) extra++;
      @(negedge clk);
    end
    // R7: request during busy starts nothing
    chk(extra == 0, "R7", "no access from busy request", 32'(extra), 32'd0);
  endtask

  task automatic t_back_to_back();
    do_read(17'h00F00);
    do_read(17'h1E00F);
    do_read(17'h00001);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * CLK_NS);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_counts();
    t_edges();
    t_hold();
    t_busy_ignore();
    t_back_to_back();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule